// File: doc/BRIEF.md
# Conditional Trap Evaluator

This block decides whether a conditional trap instruction takes its trap. It takes two operands, a 5-bit condition field and a width select, and compares the operands in two ways at once. The signed comparison gives less-than, greater-than and equal. The unsigned comparison gives less-than and greater-than. Each of those five results is gated by its own bit of the condition field. If any gated result is true, the block raises a program-exception request with a fixed trap reason code. Delivering the exception is left to the core.

In word mode only the low 32 bits of each operand take part, read as 32-bit signed or unsigned values. In doubleword mode all 64 bits take part. The request is held in a two-state machine. In `ST_IDLE` no trap is pending. In `ST_RAISE` the request is shown for one cycle. The transitions are as follows:
- `IDLE->RAISE`: a strobe whose condition hits.
- `RAISE->RAISE`: a further strobe that hits.
- `RAISE->IDLE` and `IDLE->IDLE`: any other cycle.

Top module: `trap_eval`

## Requirements
- R1: Condition bit 4 (mask value 0x10) traps when operand A is below operand B as signed numbers.
- R2: Condition bit 3 (mask value 0x08) traps when A is above B as signed numbers.
- R3: Condition bit 2 (mask value 0x04) traps when A equals B.
- R4: Condition bit 1 (mask value 0x02) traps when A is below B as unsigned numbers. Condition bit 0 (mask value 0x01) traps when A is above B as unsigned numbers.
- R5: A trap is raised when at least one enabled condition holds. While `trap_req` is high, `err_code` equals the parameter `TRAP_CODE` (default 8'h14). Otherwise `err_code` is zero.
- R6: When `dword_sel` is 0, only bits 31:0 of each operand are compared, as 32-bit signed or unsigned values. Bits 63:32 have no effect.
- R7: When `dword_sel` is 1, all 64 bits are compared.
- R8: A condition field of 0 never raises a trap.
- R9: A condition field of 5'b11111 always raises a trap.
- R10: `trap_req` rises at the first clock edge after a qualifying `in_valid` cycle and lasts one cycle per strobe. Without a strobe it stays low.
- R11: After reset, `trap_req` is 0 and `err_code` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Strobe qualifying the operands and condition |
| opnd_a | input | 64 | First operand |
| opnd_b | input | 64 | Second operand |
| cond | input | 5 | Trap condition mask |
| dword_sel | input | 1 | 1 = 64-bit compare, 0 = 32-bit compare |
| trap_req | output | 1 | Program-exception request, one cycle |
| err_code | output | 8 | Trap reason code while requesting, else 0 |

## Verification
The only internal state is the request state. A wrong state shows at the ports on the very next cycle. A stuck `ST_RAISE` state shows as a request after a cycle with no strobe, or as a request wider than one cycle. A missed transition shows as no request one cycle after a hitting strobe. A wrong compare or gating path shows in the same registered cycle, as a wrong `trap_req` value for a specific operand and mask pattern. The test patterns aim at the edges where the signed and unsigned orders disagree, and at upper operand bits that must be ignored in word mode.

// File: rtl/trap_pkg.sv
package trap_pkg;
    localparam int COND_W = 5;
    localparam int CODE_W = 8;

    // Positions of the condition flags; software encodes the mask this way.
    localparam int C_LT_S = 4;
    localparam int C_GT_S = 3;
    localparam int C_EQ   = 2;
    localparam int C_LT_U = 1;
    localparam int C_GT_U = 0;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_RAISE = 1'b1
    } trap_state_e;
endpackage

// File: rtl/trap_compare.sv
module trap_compare
    import trap_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int WORD_W = 32
) (
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    input  logic              full_width,
    output logic [COND_W-1:0] flags
);
    localparam int EXT_W = DATA_W - WORD_W;

    logic [DATA_W-1:0] a_s, b_s, a_u, b_u;

    generate
        if (EXT_W > 0) begin : g_narrow
            always_comb begin
                if (full_width) begin
                    a_s = a_in;
                    b_s = b_in;
                    a_u = a_in;
                    b_u = b_in;
                end else begin
                    a_s = {{EXT_W{a_in[WORD_W-1]}}, a_in[WORD_W-1:0]};
                    b_s = {{EXT_W{b_in[WORD_W-1]}}, b_in[WORD_W-1:0]};
                    a_u = {{EXT_W{1'b0}}, a_in[WORD_W-1:0]};
                    b_u = {{EXT_W{1'b0}}, b_in[WORD_W-1:0]};
                end
            end
        end else begin : g_flat
            assign a_s = a_in;
            assign b_s = b_in;
            assign a_u = a_in;
            assign b_u = b_in;
        end
    endgenerate

    always_comb begin
        flags         = '0;
        flags[C_LT_S] = $signed(a_s) < $signed(b_s);
        flags[C_GT_S] = $signed(a_s) > $signed(b_s);
        flags[C_EQ]   = a_u == b_u;
        flags[C_LT_U] = a_u < b_u;
        flags[C_GT_U] = a_u > b_u;
    end
endmodule

// File: rtl/trap_match.sv
module trap_match
    import trap_pkg::*;
(
    input  logic [COND_W-1:0] flags,
    input  logic [COND_W-1:0] mask,
    output logic              hit
);
    assign hit = |(flags & mask);
endmodule

// File: rtl/trap_eval.sv
module trap_eval
    import trap_pkg::*;
#(
    parameter int                DATA_W    = 64,
    parameter int                WORD_W    = 32,
    parameter logic [CODE_W-1:0] TRAP_CODE = 8'h14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [COND_W-1:0] cond,
    input  logic              dword_sel,
    output logic              trap_req,
    output logic [CODE_W-1:0] err_code
);
    logic [COND_W-1:0] flags;
    logic              hit;
    trap_state_e       state_q, state_d;

    trap_compare #(.DATA_W(DATA_W), .WORD_W(WORD_W)) cmp_i (
        .a_in      (opnd_a),
        .b_in      (opnd_b),
        .full_width(dword_sel),
        .flags     (flags)
    );

    trap_match match_i (
        .flags(flags),
        .mask (cond),
        .hit  (hit)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        unique case (state_q)
            ST_IDLE:  state_d = (in_valid && hit) ? ST_RAISE : ST_IDLE;
            ST_RAISE: state_d = (in_valid && hit) ? ST_RAISE : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ST_RAISE: begin
                trap_req = 1'b1;
                err_code = TRAP_CODE;
            end
            default: begin
                trap_req = 1'b0;
                err_code = '0;
            end
        endcase
    end

    // Exactly one of the signed ordering results holds
    assert_signed_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({flags[C_LT_S], flags[C_GT_S], flags[C_EQ]}) == 1);
    // Unsigned results never both hold, and never with equality
    assert_unsigned_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({flags[C_LT_U], flags[C_GT_U], flags[C_EQ]}) == 1);
    assert_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req ? (err_code == TRAP_CODE) : (err_code == '0));
    assert_zero_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cond == '0) |=> !trap_req);
    assert_full_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cond == '1) |=> trap_req);
    assert_needs_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !trap_req);
endmodule

// File: tb/trap_eval_tb_top.sv
module trap_eval_tb_top;
    typedef struct packed {
        logic [63:0] a;
        logic [63:0] b;
        logic [4:0]  cond;
        logic        dw;
        logic        exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        '{64'd5,                  64'd7, 5'b10000, 1'b1, 1'b1, 8'd1}, // R1
        '{64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 5'b10000, 1'b1, 1'b1, 8'd1}, // R1 -1 < 1
        '{64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 5'b00010, 1'b1, 1'b0, 8'd4}, // R4
        '{64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 5'b00001, 1'b1, 1'b1, 8'd4}, // R4
        '{64'd1,                  64'd2, 5'b00010, 1'b1, 1'b1, 8'd4}, // R4
        '{64'd9,                  64'd3, 5'b01000, 1'b1, 1'b1, 8'd2}, // R2
        '{64'd3,                  64'd9, 5'b01000, 1'b1, 1'b0, 8'd2}, // R2
        '{64'd42,                 64'd42, 5'b00100, 1'b1, 1'b1, 8'd3}, // R3
        '{64'd42,                 64'd43, 5'b00100, 1'b1, 1'b0, 8'd3}, // R3
        '{64'hFFFF_FFFF_0000_0005, 64'd5, 5'b00100, 1'b0, 1'b1, 8'd6}, // R6
        '{64'hFFFF_FFFF_0000_0005, 64'd5, 5'b00100, 1'b1, 1'b0, 8'd7}, // R7
        '{64'h0000_0000_8000_0000, 64'd1, 5'b10000, 1'b0, 1'b1, 8'd6}, // R6
        '{64'h0000_0000_8000_0000, 64'd1, 5'b10000, 1'b1, 1'b0, 8'd7}, // R7
        '{64'd1,                  64'd2, 5'b00000, 1'b1, 1'b0, 8'd8}, // R8
        '{64'd0,                  64'd0, 5'b11111, 1'b1, 1'b1, 8'd9}, // R9
        '{64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 5'b01010, 1'b1, 1'b0, 8'd5}  // R5 no enabled hit
    };
    localparam logic [7:0] CODE = 8'h14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] opnd_a = '0;
    logic [63:0] opnd_b = '0;
    logic [4:0]  cond = '0;
    logic        dword_sel = 1'b0;
    logic        trap_req;
    logic [7:0]  err_code;
    int          checks = 0;
    int          failures = 0;
    bit          finished = 1'b0;

    always #5 clk = ~clk;

    trap_eval dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opnd_a(opnd_a),
        .opnd_b(opnd_b), .cond(cond), .dword_sel(dword_sel),
        .trap_req(trap_req), .err_code(err_code)
    );

    task automatic check(input string req, input logic exp);
        logic [7:0] exp_code;
        exp_code = exp ? CODE : 8'h00;
        checks++;
        if (trap_req !== exp || err_code !== exp_code) begin
            failures++;
            $display("FAIL %s: trap_req=%0b err_code=%02h expected %0b/%02h",
                     req, trap_req, err_code, exp, exp_code);
        end
    endtask

    task automatic apply(input logic [63:0] a, input logic [63:0] b,
                         input logic [4:0] c, input logic dw);
        in_valid  = 1'b1;
        opnd_a    = a;
        opnd_b    = b;
        cond      = c;
        dword_sel = dw;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R11", 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11", 1'b0);

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i].a, VEC[i].b, VEC[i].cond, VEC[i].dw);
            @(negedge clk);
            in_valid = 1'b0;
            check($sformatf("R%0d vector %0d", VEC[i].req, i), VEC[i].exp);
            @(negedge clk);
            check("R10 single pulse", 1'b0);
        end

        // R10: back-to-back hitting strobes keep the request up
        apply(64'd1, 64'd1, 5'b00100, 1'b1);
        @(negedge clk);
        check("R10 first", 1'b1);
        apply(64'd2, 64'd1, 5'b00001, 1'b1);
        @(negedge clk);
        check("R10 second", 1'b1);
        // hitting strobe followed by missing strobe
        apply(64'd2, 64'd1, 5'b00010, 1'b1);
        @(negedge clk);
        in_valid = 1'b0;
        check("R10 miss after hit", 1'b0);

        // R10: matching inputs without a strobe do nothing
        opnd_a = 64'd0; opnd_b = 64'd0; cond = 5'b11111;
        repeat (2) @(negedge clk);
        check("R10 no strobe", 1'b0);

        // R6: upper bits differ wildly, low words signed-order -1 < 0
        apply(64'h1234_5678_FFFF_FFFF, 64'h8000_0000_0000_0000, 5'b10000, 1'b0);
        @(negedge clk);
        in_valid = 1'b0;
        check("R6 upper ignored", 1'b1);

        // R11: reset mid-request clears output
        apply(64'd0, 64'd0, 5'b11111, 1'b1);
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        #1;
        check("R11 async reset", 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule